// File: doc/BRIEF.md
# Per-Stream Write Barrier Arbiter

This block merges several independent write streams onto one write request port that targets a single, fixed virtual channel. It keeps an outstanding-write count for each stream. A write issued by a stream raises that stream's count. A write response lowers the count of the stream named in the low bits of the response's metadata tag. Every issued write carries its stream number in the low bits of its outgoing tag, so the responses can be sorted by stream.

A write that carries the barrier flag waits until its own stream has no writes outstanding. Only then is it issued. While it waits, the other streams keep issuing. A stream whose count is at the top of its range is held until a response frees a slot. Each cycle, a rotating-priority arbiter picks one eligible stream.

Each input stream has a valid/ready handshake. The merged output is a registered valid, tag and payload with no backpressure. Responses arrive as a valid pulse with a tag.

Top module: `wrbar_mux`

## Requirements
- R1: After reset all counts are zero and `wr_valid` and `req_ready` are low. The first grant when several streams request goes to stream 0.
- R2: A stream granted in cycle t (`req_valid` and `req_ready` both high) appears on the output at the next clock edge. The output has `wr_valid` high, `wr_tag` equal to the stream index in its low `$clog2(NUM_STREAMS)` bits with zero upper bits, and that stream's payload. With no grant, `wr_valid` is low after the edge.
- R3: A stream's count rises by one for each of its issued writes. It falls by one for each response whose tag low bits equal the stream index.
- R4: A write with `req_fence` high is granted only in a cycle where its stream's count is zero. Once that count is zero, the write is issued.
- R5: A stalled barrier write on one stream does not block writes from other streams.
- R6: A stream whose count equals 2**CNT_W-1 is not granted until a response lowers the count.
- R7: An issue and a response for the same stream in the same cycle leave that stream's count unchanged.
- R8: A response to a stream whose count is zero is ignored, and the count stays zero.
- R9: At most one `req_ready` bit is high per cycle, and only for a stream with `req_valid` high. Among eligible streams, the grant goes to the first one after the last granted index, wrapping round.
- R10: A response changes only the count of the stream named by its tag's low bits. The upper tag bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_STREAMS | Per-stream write request valid |
| req_fence | input | NUM_STREAMS | Per-stream barrier flag for the presented write |
| req_payload | input | NUM_STREAMS*PAYLOAD_W | Per-stream write payload, stream i at bits [i*PAYLOAD_W +: PAYLOAD_W] |
| req_ready | output | NUM_STREAMS | Per-stream grant; write accepted when valid and ready are high |
| wr_valid | output | 1 | Merged write request valid |
| wr_tag | output | TAG_W | Merged request metadata tag carrying the stream index |
| wr_payload | output | PAYLOAD_W | Merged write payload |
| rsp_valid | input | 1 | Write response valid |
| rsp_tag | input | TAG_W | Tag of the returning write response |

## Verification
The bench tests the point at which a barrier write is released. The release must come exactly one cycle after the last response, and a design off by one would release it early with a write still pending. It also fills one stream's count to the top. A design whose counter wraps would then grant a 1024th write and lose track of all outstanding writes. Another test sends an issue and a response for the same stream in the same cycle. A design that let the decrement win would release a later barrier while one write was still outstanding. Responses sent at a count of zero, or with stray upper tag bits, show up as barrier writes released too early. A long mixed phase checks every grant against a rotating-priority model. A wrong rotation there shows up as starvation or a mismatched `req_ready`.

// File: rtl/wrbar_pkg.sv
package wrbar_pkg;

    // Rotating priority: first set bit of mask after index last, wrapping.
    // Returns n when no bit is set.
    function automatic int unsigned rr_pick(input logic [31:0] mask,
                                            input int unsigned last,
                                            input int unsigned n);
        int unsigned res;
        res = n;
        for (int unsigned k = n; k >= 1; k--) begin
            if (mask[(last + k) % n]) res = (last + k) % n;
        end
        return res;
    endfunction

endpackage

// File: rtl/wrbar_ctr.sv
module wrbar_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_full
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case ({inc, dec})
            2'b10: s_d.cnt = s_q.cnt + 1'b1;
            2'b01: if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign is_zero = (s_q.cnt == '0);
    assign is_full = (s_q.cnt == '1);
endmodule

// File: rtl/wrbar_rr.sv
module wrbar_rr
    import wrbar_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     eligible,
    output logic [N-1:0]     grant,
    output logic             grant_any,
    output logic [IDX_W-1:0] grant_idx
);
    typedef struct packed {
        logic [IDX_W-1:0] last;
    } rr_st_t;

    rr_st_t s_d, s_q;
    int unsigned pick;

    always_comb begin
        s_d  = s_q;
        pick = rr_pick(32'(eligible), int'(s_q.last), N);
        grant     = '0;
        grant_any = (pick < N);
        grant_idx = IDX_W'(pick);
        if (grant_any) begin
            grant[pick[IDX_W-1:0]] = 1'b1;
            s_d.last = IDX_W'(pick);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.last <= IDX_W'(N - 1);
        else        s_q      <= s_d;
    end
endmodule

// File: rtl/wrbar_mux.sv
module wrbar_mux #(
    parameter int NUM_STREAMS = 4,
    parameter int CNT_W       = 10,
    parameter int PAYLOAD_W   = 32,
    parameter int TAG_W       = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_STREAMS-1:0]         req_valid,
    input  logic [NUM_STREAMS-1:0]         req_fence,
    input  logic [NUM_STREAMS*PAYLOAD_W-1:0] req_payload,
    output logic [NUM_STREAMS-1:0]         req_ready,
    output logic                           wr_valid,
    output logic [TAG_W-1:0]               wr_tag,
    output logic [PAYLOAD_W-1:0]           wr_payload,
    input  logic                           rsp_valid,
    input  logic [TAG_W-1:0]               rsp_tag
);
    localparam int SID_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

    typedef struct packed {
        logic                 valid;
        logic [TAG_W-1:0]     tag;
        logic [PAYLOAD_W-1:0] payload;
    } out_st_t;

    out_st_t o_d, o_q;

    logic [NUM_STREAMS-1:0]       dec, zero, full, eligible, grant;
    logic [NUM_STREAMS*CNT_W-1:0] cnt_flat;
    logic                         grant_any;
    logic [SID_W-1:0]             grant_idx;
    logic [SID_W-1:0]             rsp_sid;
    logic                         unused_tag_hi;

    assign rsp_sid       = rsp_tag[SID_W-1:0];
    assign unused_tag_hi = ^rsp_tag[TAG_W-1:SID_W];

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
        assign dec[i] = rsp_valid && (rsp_sid == SID_W'(i));
        assign eligible[i] = req_valid[i] && !full[i] && (!req_fence[i] || zero[i]);

        wrbar_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (grant[i]),
            .dec     (dec[i]),
            .count   (cnt_flat[i*CNT_W +: CNT_W]),
            .is_zero (zero[i]),
            .is_full (full[i])
        );
    end

    wrbar_rr #(.N(NUM_STREAMS), .IDX_W(SID_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (eligible),
        .grant     (grant),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    assign req_ready = grant;

    always_comb begin
        o_d         = o_q;
        o_d.valid   = grant_any;
        o_d.tag     = TAG_W'(grant_idx);
        o_d.payload = req_payload[grant_idx*PAYLOAD_W +: PAYLOAD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign wr_valid   = o_q.valid;
    assign wr_tag     = o_q.tag;
    assign wr_payload = o_q.payload;
endmodule

// File: rtl/wrbar_mux_chk.sv
module wrbar_mux_chk #(
    parameter int N     = 4,
    parameter int CNT_W = 10,
    parameter int TAG_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         req_valid,
    input logic [N-1:0]         req_fence,
    input logic [N-1:0]         req_ready,
    input logic                 rsp_valid,
    input logic [TAG_W-1:0]     rsp_tag,
    input logic                 wr_valid,
    input logic [N*CNT_W-1:0]   cnt_flat
);
    localparam int SID_W = (N > 1) ? $clog2(N) : 1;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R9
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> wr_valid); // R2
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> !wr_valid); // R2

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic hit;
        assign hit = rsp_valid && (rsp_tag[SID_W-1:0] == SID_W'(i));

        AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[i] |-> req_valid[i]); // R9
        AST_FENCE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[i] && req_fence[i]) |-> (cnt_flat[i*CNT_W +: CNT_W] == '0)); // R4
        AST_NO_ISSUE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[i] |-> (cnt_flat[i*CNT_W +: CNT_W] != '1)); // R6
        AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[i] && hit) |=> $stable(cnt_flat[i*CNT_W +: CNT_W])); // R7
        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_flat[i*CNT_W +: CNT_W] == '0) && !req_ready[i]) |=>
            (cnt_flat[i*CNT_W +: CNT_W] == '0)); // R8
        AST_RISE_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[i] && !hit) |=>
            (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1)); // R3
    end
endmodule

bind wrbar_mux wrbar_mux_chk #(
    .N     (NUM_STREAMS),
    .CNT_W (CNT_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_fence (req_fence),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .wr_valid  (wr_valid),
    .cnt_flat  (cnt_flat)
);

// File: tb/wrbar_mux_test.sv
module wrbar_mux_test;
    localparam int N     = 4;
    localparam int CW    = 10;
    localparam int PW    = 32;
    localparam int TW    = 16;
    localparam int MAXC  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  v = '0, f = '0;
    logic [PW-1:0] p [N];
    logic [N*PW-1:0] req_payload;
    logic [N-1:0]  req_ready;
    logic          wr_valid;
    logic [TW-1:0] wr_tag;
    logic [PW-1:0] wr_payload;
    logic          rsp_v = 1'b0;
    logic [TW-1:0] rsp_t = '0;

    int mcnt [N];
    int last = N - 1;
    int n_chk = 0, n_bad = 0;
    logic [N-1:0] seen_ready;

    always #2 clk = ~clk;

    assign req_payload = {p[3], p[2], p[1], p[0]};

    wrbar_mux #(.NUM_STREAMS(N), .CNT_W(CW), .PAYLOAD_W(PW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_fence(f),
        .req_payload(req_payload), .req_ready(req_ready),
        .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_payload(wr_payload),
        .rsp_valid(rsp_v), .rsp_tag(rsp_t)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int model_pick();
        int res = -1;
        for (int k = N; k >= 1; k--) begin
            int idx = (last + k) % N;
            if (v[idx] && mcnt[idx] != MAXC && (!f[idx] || mcnt[idx] == 0)) res = idx;
        end
        return res;
    endfunction

    // One clock: inputs were set at the preceding negedge.
    task automatic cycle();
        int eg;
        logic [N-1:0] er;
        logic [PW-1:0] ep;
        #1;
        eg = model_pick();
        er = (eg >= 0) ? (N'(1) << eg) : '0;
        ep = (eg >= 0) ? p[eg] : '0;
        seen_ready = req_ready;
        chk(req_ready == er, "R9 grant", 64'(req_ready), 64'(er));
        @(posedge clk); #1;
        if (eg >= 0)
            chk(wr_valid && wr_tag == TW'(eg) && wr_payload == ep, "R2 output",
                {wr_valid, 15'd0, wr_tag, wr_payload}, {1'b1, 15'd0, TW'(eg), ep});
        else
            chk(!wr_valid, "R2 idle", 64'(wr_valid), 64'd0);
        for (int i = 0; i < N; i++) begin
            bit inc = (eg == i);
            bit dec = rsp_v && (rsp_t[1:0] == 2'(i));
            if (inc && !dec) mcnt[i]++;
            else if (dec && !inc && mcnt[i] > 0) mcnt[i]--;
        end
        if (eg >= 0) last = eg;
        @(negedge clk);
        for (int i = 0; i < N; i++) p[i] = $urandom;
    endtask

    task automatic quiet();
        v = '0; f = '0; rsp_v = 1'b0;
    endtask

    task automatic respond(input int s);
        rsp_v = 1'b1;
        rsp_t = TW'(($urandom & 32'hFFFC) | s);
    endtask

    task automatic drain();
        for (int s = 0; s < N; s++) begin
            while (mcnt[s] > 0) begin
                quiet(); respond(s); cycle();
            end
        end
        quiet();
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mcnt[i] = 0; p[i] = $urandom; end
        repeat (3) @(posedge clk);
        #1;
        chk(!wr_valid, "R1 reset valid", 64'(wr_valid), 64'd0);
        chk(req_ready == '0, "R1 reset ready", 64'(req_ready), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: first grant to stream 0
        v = '1; cycle();
        chk(seen_ready == 4'b0001, "R1 first grant", 64'(seen_ready), 64'd1);
        cycle(); cycle(); cycle(); cycle();
        drain();

        // R3/R4/R5: three writes on stream 1, then barrier
        v[1] = 1'b1; repeat (3) cycle();
        f[1] = 1'b1; v[2] = 1'b1; cycle();
        chk(seen_ready[1] == 1'b0, "R4 barrier held", 64'(seen_ready[1]), 64'd0);
        chk(seen_ready[2] == 1'b1, "R5 other stream proceeds", 64'(seen_ready[2]), 64'd1);
        v[2] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            respond(1); cycle();
            chk(seen_ready[1] == 1'b0, "R3 count still nonzero", 64'(seen_ready[1]), 64'd0);
        end
        rsp_v = 1'b0; cycle();
        chk(seen_ready[1] == 1'b1, "R4 barrier released at zero", 64'(seen_ready[1]), 64'd1);
        drain();

        // R6: fill stream 3
        v[3] = 1'b1; repeat (MAXC) cycle();
        cycle();
        chk(seen_ready[3] == 1'b0, "R6 saturated stall", 64'(seen_ready[3]), 64'd0);
        respond(3); cycle();
        chk(seen_ready[3] == 1'b0, "R6 stall in response cycle", 64'(seen_ready[3]), 64'd0);
        rsp_v = 1'b0; cycle();
        chk(seen_ready[3] == 1'b1, "R6 resume after response", 64'(seen_ready[3]), 64'd1);
        drain();

        // R7: simultaneous issue and response keep the count
        v[0] = 1'b1; cycle();
        respond(0); cycle();
        chk(seen_ready[0] == 1'b1, "R7 issue with response", 64'(seen_ready[0]), 64'd1);
        rsp_v = 1'b0; f[0] = 1'b1; cycle();
        chk(seen_ready[0] == 1'b0, "R7 count kept at one", 64'(seen_ready[0]), 64'd0);
        respond(0); cycle();
        rsp_v = 1'b0; cycle();
        chk(seen_ready[0] == 1'b1, "R7 released after response", 64'(seen_ready[0]), 64'd1);
        drain();

        // R8: responses at zero are ignored
        respond(2); cycle(); cycle();
        quiet(); v[2] = 1'b1; cycle();
        f[2] = 1'b1; cycle();
        chk(seen_ready[2] == 1'b0, "R8 no underflow", 64'(seen_ready[2]), 64'd0);
        drain();

        // R10: response only credits its own stream
        v[0] = 1'b1; cycle();
        quiet(); v[1] = 1'b1; cycle();
        quiet(); rsp_v = 1'b1; rsp_t = 16'hABC1; cycle();
        quiet(); v = 4'b0011; f = 4'b0011; cycle();
        chk(seen_ready == 4'b0010, "R10 per-stream credit", 64'(seen_ready), 64'd2);
        drain();

        // Mixed traffic against the model
        for (int c = 0; c < 4000; c++) begin
            v = N'($urandom);
            f = N'($urandom) & N'($urandom) & N'($urandom);
            rsp_v = ($urandom % 4) != 0;
            rsp_t = TW'($urandom);
            cycle();
        end
        drain();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule